// File: doc/BRIEF.md
# Flash Command Decoder Responder

This block stands in for a byte-wide flash array on a synchronous bus. It keeps the array in a small internal RAM. Reads return stored bytes. Writes do not touch the array directly. Instead they are matched against the unlock-and-command write sequences that a flash device expects. A matched sequence starts an embedded operation: a byte program, an erase of one sector, or an erase of the whole array.

While an operation is running the block reports status on reads instead of data. It ignores every write. When the operation's cycle budget runs out, the array is updated and normal reads resume. A host-side sequencer can be run against this responder to check its command traffic, its wait-for-completion logic and its status polling.

The array depth, the sector count and both busy durations are parameters. Command addresses are compared against the full bus address. Array locations are selected by the low address bits, and the sector of a location is given by the top bits of that array index.

Top module: `flash_cmd_responder`

## Requirements
- R1: After reset, `busy` is 0, `rdata` is 00h, and every array byte reads FFh.
- R2: The write sequence AAh@5555h, 55h@2AAAh, A0h@5555h arms a program. The next write then programs its data byte into the location selected by its address bits [MEM_AW-1:0].
- R3: A program can only clear bits: the location afterwards holds the previous byte AND the written byte.
- R4: While `busy` is 1, a read returns a status byte: bit 7 is the inverse of bit 7 of the operation's target byte, and bits 6:0 are 0. The target byte is the programmed data, or FFh for an erase.
- R5: `busy` rises in the cycle after the write that launches an operation. It then stays 1 for exactly PROG_CYC cycles for a program, or exactly ERASE_CYC cycles for an erase.
- R6: The sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, followed by a write of 30h to any address, erases one sector to FFh. The sector is selected by index bits [MEM_AW-1 : MEM_AW-log2(NUM_SECT)] of that address, and the other sectors are unchanged.
- R7: The same five-write erase prefix followed by 10h@5555h sets every array byte to FFh.
- R8: A write that does not match the step the decoder is waiting for returns the decoder to idle. No operation starts until a complete sequence is written again.
- R9: Writes that arrive while `busy` is 1 are ignored. They change neither the array nor the decoder's progress.
- R10: With `busy` at 0, a read returns the stored byte at index addr[MEM_AW-1:0] in the cycle after `rd_en`. `rdata` holds its value in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | ADDR_W | Bus address for reads and writes |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data or status byte, registered |
| busy | output | 1 | High while an embedded operation runs |

## Verification
The assertions take for granted that reads and writes are single-cycle strobes with stable address and data in the cycle they are high. They also assume that the array only changes through a completed command, so that the status bit always follows the byte held for the running operation. The stimulus drives each strobe for exactly one cycle, away from the active edge. It never asserts `wr_en` and `rd_en` in the same cycle. The only writes it sends during a busy interval are deliberate, to test that they are ignored. Aborted sequences are followed by a fresh full prefix, so every later operation starts from an idle decoder.

// File: rtl/flr_pkg.sv
package flr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNL1,
        S_CMD,
        S_PGM,
        S_ERA1,
        S_ERA2,
        S_ERA3
    } seq_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_CHIP
    } op_e;

    localparam logic [15:0] UNL_ADDR_A = 16'h5555;
    localparam logic [15:0] UNL_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  UNL_DATA_A = 8'hAA;
    localparam logic [7:0]  UNL_DATA_B = 8'h55;
    localparam logic [7:0]  CMD_PROG   = 8'hA0;
    localparam logic [7:0]  CMD_ERASE  = 8'h80;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;
    localparam logic [7:0]  CMD_SECT   = 8'h30;

endpackage

// File: rtl/flr_seq.sv
module flr_seq
    import flr_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    output logic              launch,
    output op_e               op,
    output seq_e              state
);

    seq_e state_d, state_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                                 input logic [15:0] ca, input logic [7:0] cd);
        return (a == ADDR_W'(ca)) && (d == cd);
    endfunction

    logic wr_ok;
    assign wr_ok = wr_en && !busy;

    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        op      = OP_NONE;
        if (wr_ok) begin
            state_d = S_IDLE;
            unique case (state_q)
                S_IDLE: if (hit(addr, wdata, UNL_ADDR_A, UNL_DATA_A)) state_d = S_UNL1;
                S_UNL1: if (hit(addr, wdata, UNL_ADDR_B, UNL_DATA_B)) state_d = S_CMD;
                S_CMD: begin
                    if (hit(addr, wdata, UNL_ADDR_A, CMD_PROG))       state_d = S_PGM;
                    else if (hit(addr, wdata, UNL_ADDR_A, CMD_ERASE)) state_d = S_ERA1;
                end
                S_PGM: begin
                    launch = 1'b1;
                    op     = OP_PROG;
                end
                S_ERA1: if (hit(addr, wdata, UNL_ADDR_A, UNL_DATA_A)) state_d = S_ERA2;
                S_ERA2: if (hit(addr, wdata, UNL_ADDR_B, UNL_DATA_B)) state_d = S_ERA3;
                S_ERA3: begin
                    if (hit(addr, wdata, UNL_ADDR_A, CMD_CHIP)) begin
                        launch = 1'b1;
                        op     = OP_CHIP;
                    end else if (wdata == CMD_SECT) begin
                        launch = 1'b1;
                        op     = OP_SECT;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/flr_timer.sv
module flr_timer
    import flr_pkg::*;
#(
    parameter int MEM_AW    = 10,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  op_e               op_in,
    input  logic [MEM_AW-1:0] addr_in,
    input  logic [7:0]        data_in,
    output logic              busy,
    output logic              done,
    output op_e               op,
    output logic [MEM_AW-1:0] tgt_addr,
    output logic [7:0]        tgt_data
);

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        op_e               op;
        logic [MEM_AW-1:0] addr;
        logic [7:0]        data;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (launch) begin
            tm_d.op   = op_in;
            tm_d.addr = addr_in;
            if (op_in == OP_PROG) begin
                tm_d.cnt  = CNT_W'(PROG_CYC);
                tm_d.data = data_in;
            end else begin
                tm_d.cnt  = CNT_W'(ERASE_CYC);
                tm_d.data = 8'hFF;
            end
        end else if (tm_q.cnt != '0) begin
            tm_d.cnt = tm_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_q <= '{cnt: '0, op: OP_NONE, addr: '0, data: 8'hFF};
        else        tm_q <= tm_d;
    end

    assign busy     = (tm_q.cnt != '0);
    assign done     = (tm_q.cnt == CNT_W'(1));
    assign op       = tm_q.op;
    assign tgt_addr = tm_q.addr;
    assign tgt_data = tm_q.data;

endmodule

// File: rtl/flr_array.sv
module flr_array
    import flr_pkg::*;
#(
    parameter int MEM_AW   = 10,
    parameter int NUM_SECT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [MEM_AW-1:0] rd_addr,
    input  logic              busy,
    input  logic              apply,
    input  op_e               op,
    input  logic [MEM_AW-1:0] tgt_addr,
    input  logic [7:0]        tgt_data,
    output logic [7:0]        rdata
);

    localparam int DEPTH  = 1 << MEM_AW;
    localparam int SECT_W = $clog2(NUM_SECT);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_d, rdata_q;
    logic [SECT_W-1:0] tgt_sect;

    assign tgt_sect = tgt_addr[MEM_AW-1 -: SECT_W];

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            if (busy) rdata_d = {~tgt_data[7], 7'b0};
            else      rdata_d = mem_q[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= 8'h00;
        else        rdata_q <= rdata_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (apply) begin
            unique case (op)
                OP_PROG: mem_q[tgt_addr] <= mem_q[tgt_addr] & tgt_data;
                OP_SECT: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (SECT_W'(i >> (MEM_AW - SECT_W)) == tgt_sect) mem_q[i] <= 8'hFF;
                    end
                end
                OP_CHIP: begin
                    for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
                end
                default: ;
            endcase
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/flash_cmd_responder.sv
module flash_cmd_responder
    import flr_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int MEM_AW    = 10,
    parameter int NUM_SECT  = 8,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              busy
);

    seq_e              seq_state;
    logic              launch;
    op_e               launch_op;
    logic              done;
    op_e               run_op;
    logic [MEM_AW-1:0] tgt_addr;
    logic [7:0]        tgt_data;

    flr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .busy   (busy),
        .launch (launch),
        .op     (launch_op),
        .state  (seq_state)
    );

    flr_timer #(.MEM_AW(MEM_AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .op_in    (launch_op),
        .addr_in  (addr[MEM_AW-1:0]),
        .data_in  (wdata),
        .busy     (busy),
        .done     (done),
        .op       (run_op),
        .tgt_addr (tgt_addr),
        .tgt_data (tgt_data)
    );

    flr_array #(.MEM_AW(MEM_AW), .NUM_SECT(NUM_SECT)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (addr[MEM_AW-1:0]),
        .busy     (busy),
        .apply    (done),
        .op       (run_op),
        .tgt_addr (tgt_addr),
        .tgt_data (tgt_data),
        .rdata    (rdata)
    );

endmodule

// File: rtl/flash_cmd_responder_chk.sv
module flash_cmd_responder_chk
    import flr_pkg::*;
#(
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic [7:0] rdata,
    input logic       busy,
    input seq_e       seq_state,
    input logic       launch,
    input logic [7:0] tgt_data
);

    int run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    // R9: decoder makes no progress while an operation runs
    p_idle_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> seq_state == S_IDLE);

    // R9: no new operation can launch while busy
    p_no_launch_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !launch);

    // R5: busy follows a launch in the next cycle
    p_launch_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

    // R5: busy interval has one of the two configured lengths
    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == PROG_CYC || run_q == ERASE_CYC));

    // R4: status byte during the busy interval
    p_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> rdata == {~$past(tgt_data[7]), 7'b0});

    // R10: read data holds without a read
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind flash_cmd_responder flash_cmd_responder_chk #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .busy      (busy),
    .seq_state (seq_state),
    .launch    (launch),
    .tgt_data  (tgt_data)
);

// File: tb/flash_cmd_responder_test.sv
`timescale 1ns/1ps
module flash_cmd_responder_test;

    localparam int ADDR_W    = 17;
    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic              busy;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    flash_cmd_responder #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic unlock();
        bus_wr(17'h05555, 8'hAA);
        bus_wr(17'h02AAA, 8'h55);
    endtask

    task automatic do_program(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        unlock();
        bus_wr(17'h05555, 8'hA0);
        bus_wr(a, d);
    endtask

    task automatic erase_prefix();
        unlock();
        bus_wr(17'h05555, 8'h80);
        unlock();
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int n;
        busy_len(n);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 busy after reset", busy, 0);
        check("R1 rdata after reset", rdata, 8'h00);
        bus_rd(17'h00000, d); check("R1 array low byte", d, 8'hFF);
        bus_rd(17'h003FF, d); check("R1 array top byte", d, 8'hFF);
    endtask

    task automatic t_program();
        logic [7:0] d;
        int n;
        do_program(17'h00012, 8'hA5);
        check("R5 busy right after program write", busy, 1);
        busy_len(n);
        check("R5 program busy length", n, PROG_CYC);
        bus_rd(17'h00012, d); check("R2 programmed byte", d, 8'hA5);
        bus_rd(17'h00013, d); check("R10 neighbour byte", d, 8'hFF);
        repeat (3) @(negedge clk);
        check("R10 rdata holds without read", rdata, 8'hFF);
    endtask

    task automatic t_and_clear();
        logic [7:0] d;
        do_program(17'h00012, 8'h3C);
        bus_rd(17'h00012, d); check("R4 status for data bit7=0", d, 8'h80);
        wait_idle();
        bus_rd(17'h00012, d); check("R3 program ANDs old and new", d, 8'h24);
        do_program(17'h00020, 8'h80);
        bus_rd(17'h00020, d); check("R4 status for data bit7=1", d, 8'h00);
        wait_idle();
        bus_rd(17'h00020, d); check("R2 second program", d, 8'h80);
    endtask

    task automatic t_sector_erase();
        logic [7:0] d;
        int n;
        do_program(17'h000A5, 8'h00); wait_idle();
        do_program(17'h00180, 8'h11); wait_idle();
        erase_prefix();
        bus_wr(17'h000A0, 8'h30);
        bus_rd(17'h000A5, d); check("R4 status during erase", d, 8'h00);
        busy_len(n);
        check("R5 erase busy length", n, ERASE_CYC - 2);
        bus_rd(17'h000A5, d); check("R6 erased sector byte", d, 8'hFF);
        bus_rd(17'h00012, d); check("R6 other sector kept (0)", d, 8'h24);
        bus_rd(17'h00180, d); check("R6 other sector kept (3)", d, 8'h11);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d;
        erase_prefix();
        bus_wr(17'h00010, 8'h30);
        do_program(17'h00181, 8'h00);
        check("R9 still busy during ignored writes", busy, 1);
        wait_idle();
        bus_rd(17'h00181, d); check("R9 write while busy ignored", d, 8'hFF);
        bus_rd(17'h00012, d); check("R6 sector 0 erased", d, 8'hFF);
        bus_wr(17'h00182, 8'h00);
        check("R9 decoder idle after busy", busy, 0);
        bus_rd(17'h00182, d); check("R9 no leftover program", d, 8'hFF);
    endtask

    task automatic t_mismatch();
        logic [7:0] d;
        bus_wr(17'h05555, 8'hAA);
        bus_wr(17'h02AAA, 8'h54);
        bus_wr(17'h05555, 8'hA0);
        bus_wr(17'h00182, 8'h00);
        check("R8 no busy after bad prefix", busy, 0);
        bus_rd(17'h00182, d); check("R8 bad prefix no program", d, 8'hFF);
        erase_prefix();
        bus_wr(17'h02AAA, 8'h10);
        check("R8 no busy after bad erase cmd", busy, 0);
        bus_rd(17'h00180, d); check("R8 bad erase leaves data", d, 8'h11);
        do_program(17'h00182, 8'h5A); wait_idle();
        bus_rd(17'h00182, d); check("R8 full sequence after abort", d, 8'h5A);
    endtask

    task automatic t_chip_erase();
        logic [7:0] d;
        int n;
        erase_prefix();
        bus_wr(17'h05555, 8'h10);
        busy_len(n);
        check("R5 chip erase busy length", n, ERASE_CYC);
        bus_rd(17'h00180, d); check("R7 chip erase sector 3", d, 8'hFF);
        bus_rd(17'h00020, d); check("R7 chip erase sector 0", d, 8'hFF);
        bus_rd(17'h00182, d); check("R7 chip erase programmed byte", d, 8'hFF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_and_clear();
        t_sector_erase();
        t_busy_ignore();
        t_mismatch();
        t_chip_erase();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule